// File: doc/BRIEF.md
# DRAM Chip-Select Row Boundary Decoder

This block holds one cumulative upper-limit register for each DRAM chip-select row and maps a physical address to the row that holds it. Boundaries are counted in 64 MiB units, and each register stores the running total up to and including its own row. Row *i* therefore covers the units from the previous boundary up to one below its own. A row whose boundary does not rise above the previous one is empty. The last active register gives the total installed memory.

Software writes the boundaries through a simple write port. The address side is fully combinational: the row index, hit flag, the row's first and last unit, and the per-channel size of that row all follow `addr_i` in the same cycle. A dual-channel mode limits decoding to the lower half of the rows, and in that mode each row's capacity is split evenly between the two channels.

Top module: `dram_row_decoder`

## Requirements
- R1: When `wr_en_i` is high at a rising clock edge, bits 6:0 of `wr_data_i` are stored as the boundary of row `wr_idx_i`. The stored value governs the outputs from the following cycle. Without a write, every boundary keeps its value.
- R2: Bit 7 of `wr_data_i` is reserved, and its value has no effect on any output.
- R3: While `rst_ni` is low, all boundaries are zero. After reset `populated_o` is 0, `total_o` is 0 and `hit_o` is low for every address.
- R4: The address unit is `addr_i[ADDR_W-1:26]`. `hit_o` is high when an active row has a boundary strictly greater than this unit. `row_o` is then the lowest such row index.
- R5: A row whose boundary equals the previous row's boundary is never reported by `row_o`. For row 0, the previous boundary is zero.
- R6: On a hit, `row_first_o` is the previous boundary (zero for row 0) and `row_last_o` is the row's own boundary minus one. Without a hit, `row_o`, `row_first_o`, `row_last_o` and `chan_size_o` are all zero.
- R7: With non-decreasing boundaries, an address unit at or above `total_o` gives `hit_o` low.
- R8: `populated_o[i]` is high exactly when row *i* is active and its boundary is strictly greater than the previous boundary.
- R9: `total_o` equals the boundary of row 7 when `dual_i` is low and the boundary of row 3 when `dual_i` is high.
- R10: When `dual_i` is high, rows 4 to 7 are inactive: they never hit, and their `populated_o` bits are low.
- R11: On a hit, `chan_size_o` gives the per-channel size of the row in 32 MiB units: twice (boundary minus previous) in single-channel mode, and (boundary minus previous) in dual-channel mode.
- R12: If the boundaries are not non-decreasing, the lowest-index row whose boundary exceeds the unit still wins.
- R13: The decode outputs follow `addr_i` and `dual_i` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Boundary write strobe |
| wr_idx_i | input | 3 | Row whose boundary is written |
| wr_data_i | input | 8 | Write data; bits 6:0 are the boundary, bit 7 is reserved |
| dual_i | input | 1 | Dual-channel mode |
| addr_i | input | 33 | Physical byte address |
| hit_o | output | 1 | Address falls inside a populated row |
| row_o | output | 3 | Index of the matching row |
| row_first_o | output | 7 | First 64 MiB unit of the matching row |
| row_last_o | output | 7 | Last 64 MiB unit of the matching row |
| chan_size_o | output | 8 | Per-channel size of the matching row, in 32 MiB units |
| populated_o | output | 8 | Per-row populated flags |
| total_o | output | 7 | Total memory, in 64 MiB units |

## Verification
A boundary write and an address decode can fall in the same cycle. The bench holds an address fixed while it raises a write to the boundary that covers that address. It then samples the outputs twice: once in the low phase before the edge, where the old mapping must still hold, and once after the edge, where the new boundary must be in effect. A second collision occurs when `dual_i` toggles under a fixed address. Here the row and total outputs must switch in the same cycle without any clock edge in between.

// File: rtl/dram_row_pkg.sv
`timescale 1ns/1ps
package dram_row_pkg;
  localparam int unsigned DEF_ROWS       = 8;
  localparam int unsigned DEF_BND_W      = 7;
  localparam int unsigned DEF_DATA_W     = 8;
  localparam int unsigned DEF_ADDR_W     = 33;
  localparam int unsigned DEF_UNIT_SHIFT = 26;
endpackage

// File: rtl/drb_regfile.sv
`timescale 1ns/1ps
module drb_regfile #(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned BND_W  = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(ROWS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [ROWS-1:0][BND_W-1:0]  bnd_o
);
  logic [ROWS-1:0][BND_W-1:0] bnd_q;
  logic unused_rsvd;

  // upper data bits are reserved and dropped
  assign unused_rsvd = ^data_i[DATA_W-1:BND_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bnd_q <= '0;
    else if (we_i) bnd_q[idx_i] <= data_i[BND_W-1:0];
  end

  assign bnd_o = bnd_q;
endmodule

// File: rtl/drb_row_cmp.sv
`timescale 1ns/1ps
module drb_row_cmp #(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned BND_W  = 7,
  parameter int unsigned UNIT_W = 7,
  localparam int unsigned HALF  = ROWS / 2,
  localparam int unsigned CMP_W = (UNIT_W > BND_W) ? UNIT_W : BND_W
) (
  input  logic [ROWS-1:0][BND_W-1:0] bnd_i,
  input  logic [UNIT_W-1:0]          unit_i,
  input  logic                       dual_i,
  output logic [ROWS-1:0]            match_o,
  output logic [ROWS-1:0]            pop_o,
  output logic [ROWS-1:0][BND_W-1:0] prev_o
);
  logic [CMP_W-1:0] unit_ext;
  assign unit_ext = CMP_W'(unit_i);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic active;
    logic [BND_W-1:0] prev;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = bnd_i[i-1];
    end
    if (i < HALF) begin : g_lo
      assign active = 1'b1;
    end else begin : g_hi
      assign active = !dual_i;
    end
    assign match_o[i] = active && (unit_ext < CMP_W'(bnd_i[i]));
    assign pop_o[i]   = active && (bnd_i[i] > prev);
    assign prev_o[i]  = prev;
  end
endmodule

// File: rtl/drb_prio_pick.sv
`timescale 1ns/1ps
module drb_prio_pick #(
  parameter int unsigned ROWS  = 8,
  localparam int unsigned IDX_W = $clog2(ROWS)
) (
  input  logic [ROWS-1:0]  match_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = |match_i;
    idx_o = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dram_row_decoder.sv
`timescale 1ns/1ps
module dram_row_decoder
  import dram_row_pkg::*;
#(
  parameter int unsigned ROWS       = DEF_ROWS,
  parameter int unsigned BND_W      = DEF_BND_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned UNIT_SHIFT = DEF_UNIT_SHIFT,
  localparam int unsigned IDX_W     = $clog2(ROWS),
  localparam int unsigned UNIT_W    = ADDR_W - UNIT_SHIFT,
  localparam int unsigned HALF      = ROWS / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              dual_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  row_o,
  output logic [BND_W-1:0]  row_first_o,
  output logic [BND_W-1:0]  row_last_o,
  output logic [BND_W:0]    chan_size_o,
  output logic [ROWS-1:0]   populated_o,
  output logic [BND_W-1:0]  total_o
);
  logic [ROWS-1:0][BND_W-1:0] bnd_q;
  logic [ROWS-1:0][BND_W-1:0] prev;
  logic [ROWS-1:0]            match;
  logic [UNIT_W-1:0]          unit;
  logic [IDX_W-1:0]           pick;
  logic                       any;
  logic [BND_W-1:0]           size;
  logic                       unused_offs;

  assign unit        = addr_i[ADDR_W-1:UNIT_SHIFT];
  assign unused_offs = ^addr_i[UNIT_SHIFT-1:0];

  drb_regfile #(.ROWS(ROWS), .BND_W(BND_W), .DATA_W(DATA_W)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .idx_i  (wr_idx_i),
    .data_i (wr_data_i),
    .bnd_o  (bnd_q)
  );

  drb_row_cmp #(.ROWS(ROWS), .BND_W(BND_W), .UNIT_W(UNIT_W)) i_cmp (
    .bnd_i   (bnd_q),
    .unit_i  (unit),
    .dual_i  (dual_i),
    .match_o (match),
    .pop_o   (populated_o),
    .prev_o  (prev)
  );

  drb_prio_pick #(.ROWS(ROWS)) i_pick (
    .match_i (match),
    .hit_o   (any),
    .idx_o   (pick)
  );

  assign size = bnd_q[pick] - prev[pick];

  always_comb begin
    hit_o       = any;
    row_o       = '0;
    row_first_o = '0;
    row_last_o  = '0;
    chan_size_o = '0;
    if (any) begin
      row_o       = pick;
      row_first_o = prev[pick];
      row_last_o  = bnd_q[pick] - BND_W'(1);
      // per-channel size in half units
      chan_size_o = dual_i ? {1'b0, size} : {size, 1'b0};
    end
  end

  assign total_o = dual_i ? bnd_q[HALF-1] : bnd_q[ROWS-1];
endmodule

// File: rtl/drb_decode_chk.sv
`timescale 1ns/1ps
module drb_decode_chk #(
  parameter int unsigned ROWS       = 8,
  parameter int unsigned BND_W      = 7,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 33,
  parameter int unsigned UNIT_SHIFT = 26,
  localparam int unsigned IDX_W     = $clog2(ROWS),
  localparam int unsigned UNIT_W    = ADDR_W - UNIT_SHIFT,
  localparam int unsigned HALF      = ROWS / 2,
  localparam int unsigned CMP_W     = (UNIT_W > BND_W) ? UNIT_W : BND_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [IDX_W-1:0]           wr_idx_i,
  input logic [DATA_W-1:0]          wr_data_i,
  input logic                       dual_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       hit_o,
  input logic [IDX_W-1:0]           row_o,
  input logic [BND_W-1:0]           row_first_o,
  input logic [BND_W-1:0]           row_last_o,
  input logic [BND_W:0]             chan_size_o,
  input logic [ROWS-1:0]            populated_o,
  input logic [BND_W-1:0]           total_o,
  input logic [ROWS-1:0][BND_W-1:0] bnd_q
);
  logic [CMP_W-1:0] unit_c;
  logic             unused_chk;

  assign unit_c     = CMP_W'(addr_i[ADDR_W-1:UNIT_SHIFT]);
  assign unused_chk = ^{addr_i[UNIT_SHIFT-1:0], wr_data_i[DATA_W-1:BND_W], row_first_o, total_o};

  p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> bnd_q[$past(wr_idx_i)] == $past(wr_data_i[BND_W-1:0]));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(bnd_q));

  p_miss_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (row_o == '0 && row_first_o == '0 && row_last_o == '0 && chan_size_o == '0));

  p_hit_below_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> unit_c <= CMP_W'(row_last_o));

  p_dual_rows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i |-> (populated_o[ROWS-1:HALF] == '0 && (!hit_o || row_o < IDX_W'(HALF))));

  p_pick_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> populated_o[row_o] || (row_o != '0 && bnd_q[row_o] < bnd_q[row_o - IDX_W'(1)]));
endmodule

bind dram_row_decoder drb_decode_chk #(
  .ROWS(ROWS), .BND_W(BND_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
) i_drb_decode_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_data_i   (wr_data_i),
  .dual_i      (dual_i),
  .addr_i      (addr_i),
  .hit_o       (hit_o),
  .row_o       (row_o),
  .row_first_o (row_first_o),
  .row_last_o  (row_last_o),
  .chan_size_o (chan_size_o),
  .populated_o (populated_o),
  .total_o     (total_o),
  .bnd_q       (bnd_q)
);

// File: tb/test_dram_row_decoder.sv
`timescale 1ns/1ps
module test_dram_row_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic        dual = 1'b0;
  logic [32:0] addr = '0;
  logic        hit;
  logic [2:0]  row;
  logic [6:0]  first, last, total;
  logic [7:0]  csize, pop;

  int checks = 0;
  int fails  = 0;
  logic [6:0] mb [8];

  always #2.5 clk = ~clk;

  dram_row_decoder i_dram_row_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .dual_i(dual), .addr_i(addr), .hit_o(hit),
    .row_o(row), .row_first_o(first), .row_last_o(last),
    .chan_size_o(csize), .populated_o(pop), .total_o(total)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mb[idx] = d[6:0];
  endtask

  // expected decode from the requirements
  task automatic check_unit(input int u, input string tag);
    int n;
    logic e_hit;
    logic [2:0] e_row;
    logic [6:0] e_first, e_last, e_sz, p;
    logic [7:0] e_pop, e_cs;
    n = dual ? 4 : 8;
    e_hit = 0; e_row = 0; e_first = 0; e_last = 0; e_cs = 0; e_pop = 0;
    for (int i = 0; i < n; i++) begin
      p = (i == 0) ? 7'd0 : mb[i-1];
      if (mb[i] > p) e_pop[i] = 1'b1;
      if (!e_hit && u < int'(mb[i])) begin
        e_hit = 1; e_row = 3'(i); e_first = p; e_last = mb[i] - 7'd1;
        e_sz = mb[i] - p;
        e_cs = dual ? {1'b0, e_sz} : {e_sz, 1'b0};
      end
    end
    addr = {7'(u), 26'(u * 26'h0123457)};
    #1;
    chk({tag, " R4 hit"}, 32'(hit), 32'(e_hit));
    chk({tag, " R4 R5 row"}, 32'(row), 32'(e_row));
    chk({tag, " R6 first"}, 32'(first), 32'(e_first));
    chk({tag, " R6 last"}, 32'(last), 32'(e_last));
    chk({tag, " R11 chan_size"}, 32'(csize), 32'(e_cs));
    chk({tag, " R8 populated"}, 32'(pop), 32'(e_pop));
    chk({tag, " R9 total"}, 32'(total), 32'(dual ? mb[3] : mb[7]));
  endtask

  task automatic t_reset;
    foreach (mb[i]) mb[i] = '0;
    @(negedge clk); #1;
    chk("R3 pop in reset", 32'(pop), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 total after reset", 32'(total), 0);
    for (int u = 0; u < 128; u += 37) check_unit(u, "reset R3");
  endtask

  task automatic t_single;
    wr(0, 8'd2); wr(1, 8'd2); wr(2, 8'd5); wr(3, 8'd8);
    wr(4, 8'd8); wr(5, 8'd8); wr(6, 8'd12); wr(7, 8'd16);
    dual = 1'b0;
    for (int u = 0; u < 20; u++) check_unit(u, "single R1");
    chk("R7 at total", 32'(hit), 0);
  endtask

  task automatic t_reserved;
    wr(1, 8'h84);
    check_unit(3, "R2 rsvd");
    chk("R2 row", 32'(row), 1);
    chk("R2 last", 32'(last), 3);
    wr(1, 8'h02);
    check_unit(3, "R2 restore");
  endtask

  task automatic t_dual;
    dual = 1'b1;
    for (int u = 0; u < 20; u++) check_unit(u, "dual R10");
    addr = {7'd9, 26'd0}; #1;
    chk("R10 upper row not hit", 32'(hit), 0);
    dual = 1'b0; #1;
    chk("R13 same-cycle mode switch row", 32'(row), 6);
    chk("R13 same-cycle total", 32'(total), 16);
  endtask

  task automatic t_collide;
    addr = {7'd6, 26'd5};
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd3; wr_data = 8'd7;
    #1;
    chk("R1 old mapping before edge", 32'(row), 3);
    @(posedge clk); #1;
    chk("R1 new mapping after edge row", 32'(row), 3);
    chk("R1 new mapping after edge last", 32'(last), 6);
    @(negedge clk);
    wr_en = 1'b0; mb[3] = 7'd7;
    check_unit(7, "R1 R5 shifted");
  endtask

  task automatic t_nonmono;
    wr(0, 8'd6); wr(1, 8'd3); wr(2, 8'd9); wr(3, 8'd9);
    for (int u = 0; u < 11; u++) check_unit(u, "R12 nonmono");
    addr = {7'd4, 26'd0}; #1;
    chk("R12 row0 wins", 32'(row), 0);
  endtask

  task automatic t_max;
    wr(7, 8'hff);
    check_unit(126, "R7 max");
    check_unit(127, "R7 top");
    chk("R7 top miss", 32'(hit), 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_reserved();
    t_dual();
    t_collide();
    t_nonmono();
    t_max();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule